// File: doc/BRIEF.md
# External Interrupt Controller with Pending Flags

This block watches three external interrupt pins and turns activity on them into interrupt requests for a CPU. Each pin passes through a two-stage synchronizer. A per-source detector then looks for the event chosen by that source's sense setting. Sources 0 and 1 can sense a low level, any change, a falling edge or a rising edge. Source 2 senses edges only, falling or rising.

A detected edge event sets a pending flag. The flag sets whether or not the source is enabled. A flag is cleared in two ways: software writes a one to its bit, or the CPU acknowledges entry into that source's handler. A source that is in level mode keeps no flag. Its request follows the synchronized pin directly while the pin is held low.

Requests are gated by a per-source enable bit and by a global interrupt enable input. The CPU reaches three byte-wide registers through a simple bus with a 2-bit address: pending flags, enables and sense settings. Writes take effect at the clock edge. Reads are combinational from the address.

Top module: `ext_irq_ctrl`

## Requirements
- R1: `irq_req_o[s]` is 1 only when `gie_i` is 1 and the enable bit of source s is 1. The enable register sits at address 1. Bit 7 enables source 1, bit 6 enables source 0 and bit 5 enables source 2. Bits 4..0 read 0.
- R2: Sense register (address 2) bits [1:0] set the sense of source 0 and bits [3:2] set the sense of source 1. The encoding is 00 low level, 01 any change, 10 falling edge and 11 rising edge. Only the selected kind of event sets that source's flag.
- R3: Sense register bit 4 selects the sense of source 2: 0 is falling edge and 1 is rising edge. Source 2 has no level mode. Sense register bits 7..5 read 0.
- R4: The flag register sits at address 0. Bit 7 is the source 1 flag, bit 6 is the source 0 flag and bit 5 is the source 2 flag. Bits 4..0 always read 0. All three registers reset to 0.
- R5: A detected edge event sets the source's flag even while its enable bit and `gie_i` are 0. An edge-mode source with its flag set, its enable at 1 and `gie_i` at 1 raises its request.
- R6: A 1 on `ack_i[s]` (bit index = source number) clears flag s at the next clock edge.
- R7: Writing 1 to a flag bit clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R8: While a source is in level mode, its flag reads 0. Its request, when enabled, is 1 exactly while the synchronized pin is low.
- R9: If an event and a write-one clear (or an acknowledge) hit a flag in the same cycle, the flag ends up set.
- R10: A pin change becomes visible in the flag at the third rising clock edge after it. That is two synchronizer edges plus one flag-register edge. A level-mode request follows the pin after two edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 3 | External interrupt pins, index = source number, idle high |
| gie_i | input | 1 | Global interrupt enable from the CPU status |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 flags, 1 enables, 2 sense |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| ack_i | input | 3 | Handler-entry acknowledge, one bit per source |
| irq_req_o | output | 3 | Interrupt request per source |

## Verification
Each sense encoding is tried on a pin with both a falling and a rising transition. This separates a detector that responds to the wrong direction, or to both, from a correct one. Source 2 is run under both of its polarities. Level mode is tried with the pin held low and released, which shows that the request follows the pin while the flag stays at 0. Enable and global-enable toggling, acknowledge, and write-one versus write-zero patterns show the gating and clear rules. A write-one clear timed onto the very cycle of a new event shows that a set wins over a clear. Sampling the flag one edge before and on the third edge fixes the synchronizer latency.

// File: rtl/eic_pkg.sv
package eic_pkg;

    localparam int NSRC = 3;

    localparam logic [1:0] ADDR_FLAG  = 2'd0;
    localparam logic [1:0] ADDR_EN    = 2'd1;
    localparam logic [1:0] ADDR_SENSE = 2'd2;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic lvl_mode;
        logic low;
        logic hit;
    } det_t;

    // Bit position of a source in the flag and enable registers.
    function automatic int reg_bit(input int src);
        case (src)
            0:       return 6;
            1:       return 7;
            default: return 5;
        endcase
    endfunction

    function automatic logic sense_hit(input sense_e mode, input logic cur, input logic prev);
        case (mode)
            SNS_ANY:  return cur ^ prev;
            SNS_FALL: return prev & ~cur;
            SNS_RISE: return ~prev & cur;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stg_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;
        end else begin
            stg_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eic_detect.sv
module eic_detect
    import eic_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   s_i,
    input  sense_e mode_i,
    output det_t   det_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= s_i;
    end

    always_comb begin
        det_o.lvl_mode = (mode_i == SNS_LOW);
        det_o.low      = ~s_i;
        det_o.hit      = sense_hit(mode_i, s_i, prev_q);
    end
endmodule

// File: rtl/eic_flags.sv
module eic_flags #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hit_i,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] ack_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
        end else begin
            for (int s = 0; s < N; s++) begin
                if (lvl_i[s])                  flag_q[s] <= 1'b0;
                else if (hit_i[s])             flag_q[s] <= 1'b1;
                else if (clr_i[s] || ack_i[s]) flag_q[s] <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;

    for (genvar s = 0; s < N; s++) begin : g_chk
        a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
            (hit_i[s] && !lvl_i[s]) |=> flag_q[s]);
        a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (ack_i[s] && !hit_i[s]) |=> !flag_q[s]);
        a_r7_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
            (flag_q[s] && !clr_i[s] && !ack_i[s] && !lvl_i[s]) |=> flag_q[s]);
        a_r8_level_zero: assert property (@(posedge clk) disable iff (rst)
            (lvl_i[s] && $past(lvl_i[s])) |-> !flag_q[s]);
    end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] pin_i,
    input  logic            gie_i,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [7:0]      wr_data,
    output logic [7:0]      rd_data,
    input  logic [NSRC-1:0] ack_i,
    output logic [NSRC-1:0] irq_req_o
);
    logic [NSRC-1:0] pin_s;
    logic [NSRC-1:0] en_q;
    sense_e          sense_q [NSRC];
    det_t            det     [NSRC];
    logic [NSRC-1:0] hit, lvl, low, clr, flag;

    eic_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst (rst), .d_i (pin_i), .q_o (pin_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= '0;
            sense_q[0] <= SNS_LOW;
            sense_q[1] <= SNS_LOW;
            sense_q[2] <= SNS_FALL;
        end else if (wr_en) begin
            if (addr == ADDR_EN) begin
                for (int s = 0; s < NSRC; s++) en_q[s] <= wr_data[reg_bit(s)];
            end else if (addr == ADDR_SENSE) begin
                sense_q[0] <= sense_e'(wr_data[1:0]);
                sense_q[1] <= sense_e'(wr_data[3:2]);
                sense_q[2] <= sense_e'({1'b1, wr_data[4]});
            end
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        eic_detect u_det (
            .clk (clk), .rst (rst), .s_i (pin_s[s]),
            .mode_i (sense_q[s]), .det_o (det[s])
        );
        assign hit[s] = det[s].hit;
        assign lvl[s] = det[s].lvl_mode;
        assign low[s] = det[s].low;
        assign clr[s] = wr_en && (addr == ADDR_FLAG) && wr_data[reg_bit(s)];
        assign irq_req_o[s] = gie_i && en_q[s] && (lvl[s] ? low[s] : flag[s]);

        a_r1_gated: assert property (@(posedge clk) disable iff (rst)
            irq_req_o[s] |-> (gie_i && en_q[s]));
    end

    eic_flags #(.N(NSRC)) u_flags (
        .clk (clk), .rst (rst), .hit_i (hit), .lvl_i (lvl),
        .clr_i (clr), .ack_i (ack_i), .flag_o (flag)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_FLAG: for (int s = 0; s < NSRC; s++) rd_data[reg_bit(s)] = flag[s] & ~lvl[s];
            ADDR_EN:   for (int s = 0; s < NSRC; s++) rd_data[reg_bit(s)] = en_q[s];
            ADDR_SENSE: rd_data = {3'b000, sense_q[2][0], sense_q[1], sense_q[0]};
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] pin_i;
    logic       gie_i;
    logic       wr_en;
    logic [1:0] addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [2:0] ack_i;
    logic [2:0] irq_req_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ext_irq_ctrl u_dut (
        .clk (clk), .rst (rst), .pin_i (pin_i), .gie_i (gie_i),
        .wr_en (wr_en), .addr (addr), .wr_data (wr_data), .rd_data (rd_data),
        .ack_i (ack_i), .irq_req_o (irq_req_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); check("R4 reset flags", v, 8'h00);
        rd(2'd1, v); check("R4 reset enables", v, 8'h00);
        rd(2'd2, v); check("R4 reset sense", v, 8'h00);
        check("R1 reset requests", {5'd0, irq_req_o}, 8'h00);
    endtask

    task automatic t_layout();
        logic [7:0] v;
        wr(2'd1, 8'hFF); rd(2'd1, v); check("R1 enable layout", v, 8'hE0);
        wr(2'd2, 8'hFF); rd(2'd2, v); check("R3 sense layout", v, 8'h1F);
        wr(2'd0, 8'hFF); rd(2'd0, v); check("R4 flag low bits zero", v, 8'h00);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_fall_disabled();
        logic [7:0] v;
        wr(2'd2, 8'h02);
        wr(2'd0, 8'hE0);
        gie_i = 1'b0;
        pin_i[0] = 1'b0;
        ticks(2); rd(2'd0, v); check("R10 not yet after two edges", v, 8'h00);
        tick();   rd(2'd0, v); check("R5 fall sets while disabled", v, 8'h40);
        check("R1 no request while disabled", {5'd0, irq_req_o}, 8'h00);
        pin_i[0] = 1'b1;
        ticks(4); rd(2'd0, v); check("R2 rise ignored in fall mode", v, 8'h40);
        wr(2'd1, 8'h40);
        check("R1 gie off blocks", {5'd0, irq_req_o}, 8'h00);
        gie_i = 1'b1; #1;
        check("R5 request when enabled", {5'd0, irq_req_o}, 8'h01);
        ack_i = 3'b001; tick(); ack_i = 3'b000;
        rd(2'd0, v); check("R6 ack clears flag", v, 8'h00);
        check("R6 request drops", {5'd0, irq_req_o}, 8'h00);
        wr(2'd1, 8'h00);
        gie_i = 1'b0;
    endtask

    task automatic t_rise_src1();
        logic [7:0] v;
        wr(2'd2, 8'h0C);
        pin_i[1] = 1'b0;
        ticks(4); rd(2'd0, v); check("R2 fall ignored in rise mode", v, 8'h00);
        pin_i[1] = 1'b1;
        ticks(4); rd(2'd0, v); check("R2 rise sets src1 flag", v, 8'h80);
        wr(2'd0, 8'h7F); rd(2'd0, v); check("R7 write zero keeps", v, 8'h80);
        wr(2'd0, 8'h80); rd(2'd0, v); check("R7 write one clears", v, 8'h00);
    endtask

    task automatic t_any();
        logic [7:0] v;
        wr(2'd2, 8'h01);
        pin_i[0] = 1'b0;
        ticks(4); rd(2'd0, v); check("R2 any change falling", v, 8'h40);
        wr(2'd0, 8'h40);
        pin_i[0] = 1'b1;
        ticks(4); rd(2'd0, v); check("R2 any change rising", v, 8'h40);
        wr(2'd0, 8'h40);
    endtask

    task automatic t_src2();
        logic [7:0] v;
        wr(2'd2, 8'h00);
        pin_i[2] = 1'b0;
        ticks(4); rd(2'd0, v); check("R3 src2 falling", v, 8'h20);
        wr(2'd0, 8'h20);
        pin_i[2] = 1'b1;
        ticks(4); rd(2'd0, v); check("R3 src2 rise ignored", v, 8'h00);
        wr(2'd2, 8'h10);
        pin_i[2] = 1'b0;
        ticks(4); rd(2'd0, v); check("R3 src2 fall ignored", v, 8'h00);
        pin_i[2] = 1'b1;
        ticks(4); rd(2'd0, v); check("R3 src2 rising", v, 8'h20);
        wr(2'd0, 8'h20);
    endtask

    task automatic t_level();
        logic [7:0] v;
        wr(2'd2, 8'h00);
        wr(2'd1, 8'h80);
        gie_i = 1'b1;
        pin_i[1] = 1'b0;
        ticks(1); check("R10 level not yet", {5'd0, irq_req_o}, 8'h00);
        ticks(1); check("R8 level request", {5'd0, irq_req_o}, 8'h02);
        rd(2'd0, v); check("R8 flag reads zero in level", v, 8'h00);
        wr(2'd1, 8'h00);
        check("R1 level gated by enable", {5'd0, irq_req_o}, 8'h00);
        wr(2'd1, 8'h80);
        pin_i[1] = 1'b1;
        ticks(3); check("R8 request drops on release", {5'd0, irq_req_o}, 8'h00);
        wr(2'd1, 8'h00);
        gie_i = 1'b0;
    endtask

    task automatic t_collide();
        logic [7:0] v;
        wr(2'd2, 8'h01);
        pin_i[0] = 1'b0;
        ticks(4); rd(2'd0, v); check("R9 setup flag", v, 8'h40);
        pin_i[0] = 1'b1;
        ticks(2);
        wr(2'd0, 8'h40);
        rd(2'd0, v); check("R9 set wins over clear", v, 8'h40);
        wr(2'd0, 8'h40);
        rd(2'd0, v); check("R7 clear afterwards", v, 8'h00);
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; pin_i = 3'b111; gie_i = 1'b0; wr_en = 1'b0;
        addr = 2'd0; wr_data = 8'h00; ack_i = 3'b000;
        @(negedge clk);
        ticks(3);
        rst = 1'b0;
        tick();
        t_reset();
        t_layout();
        t_fall_disabled();
        t_rise_src1();
        t_any();
        t_src2();
        t_level();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule